// File: doc/BRIEF.md
# Gated Configuration Register File

This block holds the configuration and status bytes of a sensor-interface chip. It has 128 byte addresses and a host reaches it over a plain register bus: a 7-bit address, a write byte with a write strobe, and a read strobe that returns a registered read byte. Every write is classified by address. Depending on that class and on the device-enable level, the write is committed in full or rejected in full. A rejected write raises a one-cycle flag and changes nothing.

The enable level lives in bit 7 of the control byte at 0x02. Two bytes, 0x02 and 0x17, have rules at bit level. Their low or mode bits are frozen while the device is enabled. Enabling is legal only when the rest of the control byte is left as it is, and bit 3 of 0x17 must always stay set.

When the device goes from standby to enabled, a four-byte error buffer at 0x40–0x43 is loaded from the bytes at 0x30–0x33, with its second byte cleared. A pulse from the external storage engine reporting a failed write marks this buffer invalid until the next enable. Some read windows mirror other bytes, and a fixed chip-release code can be read at two addresses. The configuration bytes drive the rest of the chip through a flat output bus.

Top module: `cfgrf_top`

## Requirements
- R1: A committed write to 0x02 sets `dev_enable` to bit 7 of the written byte. A read of 0x02 always returns 0 in bit 7 and the stored bits 6:0 in bits 6:0.
- R2: Writes to 0x00, 0x03–0x16, 0x18–0x21 and 0x30–0x33 commit only while `dev_enable` is 0. Otherwise they are rejected and the stored byte keeps its value.
- R3: Writes to 0x01 and 0x2B–0x2E always commit. Writes to 0x2F, 0x34–0x43, 0x22–0x2A and 0x44–0x7F are always rejected.
- R4: While enabled, a write to 0x02 is rejected if its bits 6:0 differ from the stored ones. In standby, a write to 0x02 with bit 7 set is rejected if its bits 6:0 differ from the stored ones. Any other write to 0x02 commits.
- R5: A write to 0x17 with bit 3 clear is always rejected. While enabled, a write to 0x17 is also rejected if bits 7:4 or 2:0 differ from the stored byte.
- R6: Reads return the following:
  - 0x00 from 0x22–0x2A, 0x34–0x3A and 0x44–0x7F.
  - The bytes at 0x2B–0x2E from 0x3B–0x3E.
  - The `CHIP_REL` parameter (default 0x08) from both 0x2F and 0x3F.
  - The stored bytes from 0x00–0x21, 0x2B–0x2E and 0x30–0x33.
- R7: On each 0-to-1 change of `dev_enable`, the buffer is loaded as follows: byte 0x40 from 0x30, byte 0x41 with 0x00, byte 0x42 from 0x32 and byte 0x43 from 0x33. The buffer is then marked valid.
- R8: A `store_fail` pulse marks the buffer invalid. While it is invalid, reads of 0x40–0x43 return 0x00. It becomes valid again only at the next 0-to-1 change of `dev_enable`. If a fail pulse arrives in the same cycle as an enable, the fail wins.
- R9: Synchronous reset clears every byte except 0x17, which resets to 0x08. After reset, `dev_enable` is 0, `write_rejected` is 0 and the buffer is valid with zero contents.
- R10: Writes take effect at the clock edge that samples `wr_en`. `write_rejected` is high for exactly the cycle after a rejected write strobe. `rd_data` is updated one cycle after `rd_en` and otherwise holds its value.
- R11: `cfg_bytes[8k+7:8k]` carries the stored byte at address k, for k from 0x00 to 0x33. Byte 0x02 carries the enable level in its bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 7 | Register byte address |
| wr_data | input | 8 | Write byte |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| store_fail | input | 1 | Failed-storage-write pulse |
| rd_data | output | 8 | Registered read byte |
| write_rejected | output | 1 | One-cycle pulse after a rejected write |
| dev_enable | output | 1 | Device enable level |
| cfg_bytes | output | 416 | Stored bytes 0x00–0x33, byte k at bits 8k+7:8k |

## Verification
The same kinds of write are issued in standby and again while enabled. Comparing the two separates address-class gating from the enable level. At 0x02 and 0x17 the writes are split three ways: writes that change only permitted bits, writes that change a frozen bit, and writes that repeat the stored value. This tells bit-level rejection apart from whole-byte gating. Reads sweep the stored, mirrored, chip-release and empty windows, so that a wrong offset in a mirror shows up as a wrong byte. An enable, disable and re-enable sequence with fresh source bytes, plus fail pulses both alone and coincident with an enable, separates seeding, clearing of the second byte and invalidation.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;

    localparam int ADDR_W    = 7;
    localparam int BYTE_W    = 8;
    localparam int CFG_BYTES = 52;          // stored addresses 0x00..0x33
    localparam int ERR_BYTES = 4;
    localparam int ERR_CLEAR = 1;           // buffer byte forced to zero on seeding
    localparam int MODE_KEEP = 3;           // bit of the mode byte that must stay set

    localparam logic [ADDR_W-1:0] A_CTRL     = 7'h02;
    localparam logic [ADDR_W-1:0] A_MODE     = 7'h17;
    localparam logic [ADDR_W-1:0] A_SRC      = 7'h30;
    localparam logic [ADDR_W-1:0] A_MIRROR   = 7'h3B;
    localparam logic [ADDR_W-1:0] A_OEM      = 7'h2B;
    localparam logic [BYTE_W-1:0] MODE_RESET = 8'h08;

    typedef enum logic [2:0] {
        WC_OPEN,
        WC_STANDBY,
        WC_CTRL,
        WC_MODE,
        WC_LOCKED
    } wclass_e;

    typedef enum logic [2:0] {
        RR_NONE,
        RR_STORED,
        RR_CTRL,
        RR_MIRROR,
        RR_CHIPREL,
        RR_ERRBUF
    } rregion_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic in_rng(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] lo,
                                    logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic wclass_e write_class(logic [ADDR_W-1:0] a);
        if (a == A_CTRL)                       return WC_CTRL;
        if (a == A_MODE)                       return WC_MODE;
        if (a == 7'h01 || in_rng(a, 7'h2B, 7'h2E)) return WC_OPEN;
        if (a == 7'h00 || in_rng(a, 7'h03, 7'h16) ||
            in_rng(a, 7'h18, 7'h21) || in_rng(a, 7'h30, 7'h33))
                                               return WC_STANDBY;
        return WC_LOCKED;
    endfunction

    function automatic rregion_e read_region(logic [ADDR_W-1:0] a);
        if (a == A_CTRL)                       return RR_CTRL;
        if (a == 7'h2F || a == 7'h3F)          return RR_CHIPREL;
        if (in_rng(a, 7'h3B, 7'h3E))           return RR_MIRROR;
        if (in_rng(a, 7'h40, 7'h43))           return RR_ERRBUF;
        if (in_rng(a, 7'h00, 7'h21) || in_rng(a, 7'h2B, 7'h2E) ||
            in_rng(a, 7'h30, 7'h33))           return RR_STORED;
        return RR_NONE;
    endfunction

    function automatic logic [BYTE_W-1:0] reset_value(int k);
        return (k == int'(A_MODE)) ? MODE_RESET : '0;
    endfunction

endpackage

// File: rtl/cfgrf_wr_gate.sv
module cfgrf_wr_gate
    import cfgrf_pkg::*;
(
    input  logic              req_valid,
    input  wr_req_t           req,
    input  logic              enabled,
    input  logic [BYTE_W-1:0] ctrl_byte,
    input  logic [BYTE_W-1:0] mode_byte,
    output logic              accept,
    output logic              reject
);
    localparam logic [BYTE_W-1:0] MODE_FREE_MASK = ~(BYTE_W'(1) << MODE_KEEP);

    wclass_e cls;
    logic    ok;
    logic    low_changed;
    logic    mode_changed;

    always_comb begin
        cls          = write_class(req.addr);
        low_changed  = req.data[BYTE_W-2:0] != ctrl_byte[BYTE_W-2:0];
        mode_changed = (req.data & MODE_FREE_MASK) != (mode_byte & MODE_FREE_MASK);
        unique case (cls)
            WC_OPEN:    ok = 1'b1;
            WC_STANDBY: ok = !enabled;
            WC_CTRL:    ok = enabled ? !low_changed
                                     : !(req.data[BYTE_W-1] && low_changed);
            WC_MODE:    ok = req.data[MODE_KEEP] && (!enabled || !mode_changed);
            default:    ok = 1'b0;
        endcase
        accept = req_valid && ok;
        reject = req_valid && !ok;
    end

endmodule

// File: rtl/cfgrf_store.sv
module cfgrf_store
    import cfgrf_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                commit,
    input  wr_req_t                             req,
    input  logic                                store_fail,
    output logic [CFG_BYTES-1:0][BYTE_W-1:0]    cfg_q,
    output logic [ERR_BYTES-1:0][BYTE_W-1:0]    err_q,
    output logic                                err_valid_q
);
    localparam int SRC_IDX = int'(A_SRC);

    logic en_rise;
    assign en_rise = commit && (req.addr == A_CTRL) && req.data[BYTE_W-1]
                     && !cfg_q[int'(A_CTRL)][BYTE_W-1];

    for (genvar k = 0; k < CFG_BYTES; k++) begin : g_byte
        if (write_class(ADDR_W'(k)) != WC_LOCKED) begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)
                    cfg_q[k] <= reset_value(k);
                else if (commit && req.addr == ADDR_W'(k))
                    cfg_q[k] <= req.data;
            end
        end else begin : g_none
            assign cfg_q[k] = '0;
        end
    end

    for (genvar e = 0; e < ERR_BYTES; e++) begin : g_err
        always_ff @(posedge clk) begin
            if (rst)
                err_q[e] <= '0;
            else if (en_rise)
                err_q[e] <= (e == ERR_CLEAR) ? '0 : cfg_q[SRC_IDX + e];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            err_valid_q <= 1'b1;
        else if (store_fail)
            err_valid_q <= 1'b0;
        else if (en_rise)
            err_valid_q <= 1'b1;
    end

    // R5: bit 3 of the mode byte is never observed clear
    a_r5_mode_keep: assert property (@(posedge clk) disable iff (rst)
        cfg_q[int'(A_MODE)][MODE_KEEP]);

    // R7: a rising enable leaves the buffer holding the seed pattern
    a_r7_seed_copy: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_q[int'(A_CTRL)][BYTE_W-1]) |->
            err_q[0] == cfg_q[SRC_IDX] && err_q[ERR_CLEAR] == '0 &&
            err_q[2] == cfg_q[SRC_IDX + 2] && err_q[3] == cfg_q[SRC_IDX + 3]);

    // R8: a fail pulse always leaves the buffer invalid
    a_r8_fail_invalid: assert property (@(posedge clk) disable iff (rst)
        store_fail |=> !err_valid_q);

endmodule

// File: rtl/cfgrf_rd_mux.sv
module cfgrf_rd_mux
    import cfgrf_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CHIP_REL = 8'h08
) (
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [CFG_BYTES-1:0][BYTE_W-1:0]    cfg_q,
    input  logic [ERR_BYTES-1:0][BYTE_W-1:0]    err_q,
    input  logic                                err_valid,
    output logic [BYTE_W-1:0]                   rd_byte
);
    localparam logic [ADDR_W-1:0] MIRROR_OFS = A_MIRROR - A_OEM;

    rregion_e          region;
    logic [ADDR_W-1:0] mirrored;

    always_comb begin
        region   = read_region(addr);
        mirrored = addr - MIRROR_OFS;
        unique case (region)
            RR_STORED:  rd_byte = cfg_q[addr[5:0]];
            RR_CTRL:    rd_byte = {1'b0, cfg_q[int'(A_CTRL)][BYTE_W-2:0]};
            RR_MIRROR:  rd_byte = cfg_q[mirrored[5:0]];
            RR_CHIPREL: rd_byte = CHIP_REL;
            RR_ERRBUF:  rd_byte = err_valid ? err_q[addr[1:0]] : '0;
            default:    rd_byte = '0;
        endcase
    end

endmodule

// File: rtl/cfgrf_top.sv
module cfgrf_top
    import cfgrf_pkg::*;
#(
    parameter logic [7:0] CHIP_REL = 8'h08
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [6:0]                   addr,
    input  logic [7:0]                   wr_data,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic                         store_fail,
    output logic [7:0]                   rd_data,
    output logic                         write_rejected,
    output logic                         dev_enable,
    output logic [CFG_BYTES*BYTE_W-1:0]  cfg_bytes
);
    wr_req_t                             req;
    logic                                accept;
    logic                                reject;
    logic [CFG_BYTES-1:0][BYTE_W-1:0]    cfg_q;
    logic [ERR_BYTES-1:0][BYTE_W-1:0]    err_q;
    logic                                err_valid;
    logic [BYTE_W-1:0]                   rd_byte;

    assign req = '{addr: addr, data: wr_data};

    cfgrf_wr_gate u_gate (
        .req_valid (wr_en),
        .req       (req),
        .enabled   (dev_enable),
        .ctrl_byte (cfg_q[int'(A_CTRL)]),
        .mode_byte (cfg_q[int'(A_MODE)]),
        .accept    (accept),
        .reject    (reject)
    );

    cfgrf_store u_store (
        .clk         (clk),
        .rst         (rst),
        .commit      (accept),
        .req         (req),
        .store_fail  (store_fail),
        .cfg_q       (cfg_q),
        .err_q       (err_q),
        .err_valid_q (err_valid)
    );

    cfgrf_rd_mux #(.CHIP_REL(CHIP_REL)) u_rd (
        .addr      (addr),
        .cfg_q     (cfg_q),
        .err_q     (err_q),
        .err_valid (err_valid),
        .rd_byte   (rd_byte)
    );

    assign dev_enable = cfg_q[int'(A_CTRL)][BYTE_W-1];
    assign cfg_bytes  = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data        <= '0;
            write_rejected <= 1'b0;
        end else begin
            write_rejected <= reject;
            if (rd_en)
                rd_data <= rd_byte;
        end
    end

    // R2: standby-class writes while enabled leave every byte unchanged
    a_r2_standby_locked: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dev_enable && write_class(addr) == WC_STANDBY) |=> $stable(cfg_bytes));

    // R4: while enabled, bits 6:0 of the control byte cannot move
    a_r4_ctrl_low_frozen: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dev_enable) |=> $stable(cfg_bytes[22:16]));

    // R10: the reject flag only follows a write strobe
    a_r10_reject_after_write: assert property (@(posedge clk) disable iff (rst)
        write_rejected |-> $past(wr_en));

    // R10: read data holds without a read strobe
    a_r10_rd_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/cfgrf_top_tb_top.sv
`timescale 1ns/1ps
module cfgrf_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        store_fail = 1'b0;
    logic [7:0]  rd_data;
    logic        write_rejected;
    logic        dev_enable;
    logic [415:0] cfg_bytes;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cfgrf_top dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
        .rd_en(rd_en), .store_fail(store_fail), .rd_data(rd_data),
        .write_rejected(write_rejected), .dev_enable(dev_enable), .cfg_bytes(cfg_bytes)
    );

    typedef struct packed {
        logic       is_wr;
        logic [6:0] a;
        logic [7:0] d;
        logic       rej;
        logic [7:0] rd;
        logic       en;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 44;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 7'h17, 8'h00, 1'b0, 8'h08, 1'b0, 4'd9},  // R9 mode reset value
        '{1'b0, 7'h02, 8'h00, 1'b0, 8'h00, 1'b0, 4'd9},
        '{1'b1, 7'h00, 8'hAA, 1'b0, 8'h00, 1'b0, 4'd2},  // R2 standby write
        '{1'b0, 7'h00, 8'h00, 1'b0, 8'hAA, 1'b0, 4'd2},
        '{1'b1, 7'h02, 8'h05, 1'b0, 8'h00, 1'b0, 4'd4},  // R4 low bits in standby
        '{1'b0, 7'h02, 8'h00, 1'b0, 8'h05, 1'b0, 4'd4},
        '{1'b1, 7'h30, 8'h11, 1'b0, 8'h00, 1'b0, 4'd2},
        '{1'b1, 7'h31, 8'h22, 1'b0, 8'h00, 1'b0, 4'd2},
        '{1'b1, 7'h32, 8'h33, 1'b0, 8'h00, 1'b0, 4'd2},
        '{1'b1, 7'h33, 8'h44, 1'b0, 8'h00, 1'b0, 4'd2},
        '{1'b1, 7'h2B, 8'hC1, 1'b0, 8'h00, 1'b0, 4'd3},  // R3 open byte
        '{1'b1, 7'h2F, 8'h55, 1'b1, 8'h00, 1'b0, 4'd3},  // R3 chip code locked
        '{1'b0, 7'h2F, 8'h00, 1'b0, 8'h08, 1'b0, 4'd6},  // R6
        '{1'b0, 7'h3F, 8'h00, 1'b0, 8'h08, 1'b0, 4'd6},
        '{1'b0, 7'h3B, 8'h00, 1'b0, 8'hC1, 1'b0, 4'd6},
        '{1'b0, 7'h25, 8'h00, 1'b0, 8'h00, 1'b0, 4'd6},
        '{1'b0, 7'h36, 8'h00, 1'b0, 8'h00, 1'b0, 4'd6},
        '{1'b0, 7'h50, 8'h00, 1'b0, 8'h00, 1'b0, 4'd6},
        '{1'b1, 7'h22, 8'h12, 1'b1, 8'h00, 1'b0, 4'd3},  // R3 unmapped
        '{1'b1, 7'h17, 8'h00, 1'b1, 8'h00, 1'b0, 4'd5},  // R5 keep bit cleared
        '{1'b0, 7'h17, 8'h00, 1'b0, 8'h08, 1'b0, 4'd5},
        '{1'b1, 7'h17, 8'hF8, 1'b0, 8'h00, 1'b0, 4'd5},
        '{1'b0, 7'h17, 8'h00, 1'b0, 8'hF8, 1'b0, 4'd5},
        '{1'b1, 7'h02, 8'h86, 1'b1, 8'h00, 1'b0, 4'd4},  // R4 enable with change
        '{1'b1, 7'h02, 8'h85, 1'b0, 8'h00, 1'b1, 4'd4},  // R4 clean enable
        '{1'b0, 7'h02, 8'h00, 1'b0, 8'h05, 1'b1, 4'd1},  // R1 bit 7 hidden
        '{1'b0, 7'h40, 8'h00, 1'b0, 8'h11, 1'b1, 4'd7},  // R7 seeded
        '{1'b0, 7'h41, 8'h00, 1'b0, 8'h00, 1'b1, 4'd7},
        '{1'b0, 7'h42, 8'h00, 1'b0, 8'h33, 1'b1, 4'd7},
        '{1'b0, 7'h43, 8'h00, 1'b0, 8'h44, 1'b1, 4'd7},
        '{1'b1, 7'h00, 8'hBB, 1'b1, 8'h00, 1'b1, 4'd2},  // R2 blocked when enabled
        '{1'b0, 7'h00, 8'h00, 1'b0, 8'hAA, 1'b1, 4'd2},
        '{1'b1, 7'h01, 8'h77, 1'b0, 8'h00, 1'b1, 4'd3},
        '{1'b0, 7'h01, 8'h00, 1'b0, 8'h77, 1'b1, 4'd3},
        '{1'b1, 7'h02, 8'h86, 1'b1, 8'h00, 1'b1, 4'd4},
        '{1'b1, 7'h17, 8'hE8, 1'b1, 8'h00, 1'b1, 4'd5},  // R5 frozen bits
        '{1'b1, 7'h17, 8'hF8, 1'b0, 8'h00, 1'b1, 4'd5},  // R5 unchanged accepted
        '{1'b0, 7'h17, 8'h00, 1'b0, 8'hF8, 1'b1, 4'd5},
        '{1'b1, 7'h30, 8'h99, 1'b1, 8'h00, 1'b1, 4'd2},
        '{1'b1, 7'h40, 8'h12, 1'b1, 8'h00, 1'b1, 4'd3},
        '{1'b1, 7'h02, 8'h05, 1'b0, 8'h00, 1'b0, 4'd1},  // R1 disable
        '{1'b1, 7'h30, 8'h99, 1'b0, 8'h00, 1'b0, 4'd2},
        '{1'b1, 7'h02, 8'h85, 1'b0, 8'h00, 1'b1, 4'd7},
        '{1'b0, 7'h40, 8'h00, 1'b0, 8'h99, 1'b1, 4'd7}   // R7 reseeded
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [6:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [6:0] a);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state at the ports
        chk("R9 dev_enable", 32'(dev_enable), 32'd0);
        chk("R9 write_rejected", 32'(write_rejected), 32'd0);
        chk("R9 mode byte out", 32'(cfg_bytes[8*'h17 +: 8]), 32'h08);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_wr) begin
                do_wr(VEC[i].a, VEC[i].d);
                chk($sformatf("R%0d wr %0h rejected", VEC[i].req, VEC[i].a),
                    32'(write_rejected), 32'(VEC[i].rej));
            end else begin
                do_rd(VEC[i].a);
                chk($sformatf("R%0d rd %0h", VEC[i].req, VEC[i].a),
                    32'(rd_data), 32'(VEC[i].rd));
            end
            chk($sformatf("R%0d vec %0d enable", VEC[i].req, i),
                32'(dev_enable), 32'(VEC[i].en));
        end

        // R11: configuration bytes on the flat output
        chk("R11 byte 00", 32'(cfg_bytes[0 +: 8]), 32'hAA);
        chk("R11 byte 02", 32'(cfg_bytes[16 +: 8]), 32'h85);
        chk("R11 byte 17", 32'(cfg_bytes[8*'h17 +: 8]), 32'hF8);
        chk("R11 byte 30", 32'(cfg_bytes[8*'h30 +: 8]), 32'h99);

        // R10: read data holds, reject flag lasts one cycle
        @(negedge clk);
        chk("R10 rd hold", 32'(rd_data), 32'h99);
        do_wr(7'h2F, 8'h01);
        chk("R10 reject high", 32'(write_rejected), 32'd1);
        @(negedge clk);
        chk("R10 reject one cycle", 32'(write_rejected), 32'd0);

        // R8: fail pulse invalidates the buffer
        store_fail = 1'b1;
        @(negedge clk);
        store_fail = 1'b0;
        do_rd(7'h40);
        chk("R8 invalid reads zero", 32'(rd_data), 32'h00);
        do_rd(7'h43);
        chk("R8 invalid reads zero 43", 32'(rd_data), 32'h00);
        do_wr(7'h02, 8'h05);
        do_rd(7'h40);
        chk("R8 still invalid in standby", 32'(rd_data), 32'h00);
        // R8: fail coinciding with enable wins
        store_fail = 1'b1;
        do_wr(7'h02, 8'h85);
        store_fail = 1'b0;
        chk("R8 enable with fail", 32'(dev_enable), 32'd1);
        do_rd(7'h40);
        chk("R8 fail wins", 32'(rd_data), 32'h00);
        do_wr(7'h02, 8'h05);
        do_wr(7'h02, 8'h85);
        do_rd(7'h40);
        chk("R8 valid after toggle", 32'(rd_data), 32'h99);

        // R9: reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 enable cleared", 32'(dev_enable), 32'd0);
        chk("R9 byte 00 cleared", 32'(cfg_bytes[0 +: 8]), 32'h00);
        chk("R9 mode restored", 32'(cfg_bytes[8*'h17 +: 8]), 32'h08);
        do_rd(7'h40);
        chk("R9 buffer zero", 32'(rd_data), 32'h00);

        summary();
    end

endmodule